// File: doc/BRIEF.md
# Crosstalk Victim-Walk Test Pattern Generator

This block drives a self-test stream onto an n-lane on-chip link so that every lane is exercised against the worst coupling its neighbours can cause. It takes one lane at a time as the victim and holds all the other lanes together as aggressors that switch in unison. For each victim it plays a fixed eight-step sequence of (victim, aggressor) levels. The transitions in that sequence cover six crosstalk fault types: speed-up of a rising and of a falling victim edge, delay of a rising and of a falling victim edge, and a positive and a negative glitch on a quiet victim.

Once every lane has served as victim, the block reports completion with a one-cycle pulse and returns to idle. The stream has 8 beats per lane, so 8·LANES beats in total.

The word leaves the block on a valid/ready interface. The block holds a beat, and the sequence does not move, until the receiver accepts it. A beat is accepted on a rising clock edge where `valid_o` and `ready_i` are both high. While `valid_o` is high and `ready_i` is low, `word_o` stays unchanged. `valid_o` never drops without an accepted beat except at reset. `ready_i` may be held low for as long as the receiver needs. The step-to-level table and the lane-selection decode live inside the block. No error checking at the far end is done here.

Top module: `maf_xtalk_gen`

## Requirements
- R1: After reset and whenever the block is idle, `valid_o` is 0, `word_o` is all zeros and `finish_o` is 0 (except for the finish pulse of R7).
- R2: A high `start_i` sampled while idle makes `valid_o` high in the next cycle, with victim lane 0 and step 1 presented.
- R3: In step k (1..8) the victim lane carries level V and every other lane carries level A. (V,A) is (0,0), (1,1), (0,0), (0,1), (1,0), (0,1), (1,1), (1,0) for k = 1..8, so a lane's bit i equals V when i is the victim index and A otherwise.
- R4: The step advances only on an accepted beat. While `valid_o` is high and `ready_i` is low, `valid_o` stays high and `word_o` stays unchanged.
- R5: Victims are taken in ascending lane order, starting at bit 0. The victim index moves up by one when step 8 is accepted.
- R6: One test delivers exactly 8·LANES accepted beats. `valid_o` is low in the cycle after the step-8 beat of lane LANES-1 is accepted.
- R7: `finish_o` is high for exactly one cycle, the cycle right after the final beat is accepted, and `valid_o` is low in that cycle.
- R8: `start_i` while a test is running is ignored: the beat sequence continues unchanged and the beat count is still 8·LANES.
- R9: A new `start_i` may be given in the cycle in which `finish_o` is high, and it starts a new test as in R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to begin a test; honoured only while idle |
| ready_i | input | 1 | Receiver accepts the current beat |
| word_o | output | LANES | Test word, one bit per link lane |
| valid_o | output | 1 | A test beat is present on `word_o` |
| finish_o | output | 1 | One-cycle pulse after the last beat of a test |

## Verification
The assertions assume that `ready_i` and `start_i` are defined, synchronous to `clk` and free of glitches. They make no assumption about how long the receiver stalls or how often `start_i` pulses. The stimulus changes inputs only on the falling edge and varies `ready_i` with a deterministic pattern that contains runs of acceptance and stalls of several cycles. It also pulses `start_i` in the middle of a test and in the finish cycle. Every beat in the exhaustive walk of a four-lane configuration is compared against a word computed arithmetically from the beat number: the victim index is beat/8 and the step is beat mod 8.

// File: rtl/maf_xtalk_pkg.sv
package maf_xtalk_pkg;

  typedef enum logic [3:0] {
    ST_IDLE = 4'd0,
    ST_P1   = 4'd1,
    ST_P2   = 4'd2,
    ST_P3   = 4'd3,
    ST_P4   = 4'd4,
    ST_P5   = 4'd5,
    ST_P6   = 4'd6,
    ST_P7   = 4'd7,
    ST_P8   = 4'd8
  } step_t;

  typedef struct packed {
    logic vic;
    logic agg;
  } lvl_t;

  // Level pair for each step: the transitions between steps form the
  // six maximal-aggressor fault cases on the victim lane.
  function automatic lvl_t step_levels(step_t s);
    lvl_t l;
    unique case (s)
      ST_P1:   l = '{vic: 1'b0, agg: 1'b0};
      ST_P2:   l = '{vic: 1'b1, agg: 1'b1};
      ST_P3:   l = '{vic: 1'b0, agg: 1'b0};
      ST_P4:   l = '{vic: 1'b0, agg: 1'b1};
      ST_P5:   l = '{vic: 1'b1, agg: 1'b0};
      ST_P6:   l = '{vic: 1'b0, agg: 1'b1};
      ST_P7:   l = '{vic: 1'b1, agg: 1'b1};
      ST_P8:   l = '{vic: 1'b1, agg: 1'b0};
      default: l = '{vic: 1'b0, agg: 1'b0};
    endcase
    return l;
  endfunction

endpackage

// File: rtl/maf_seq_fsm.sv
module maf_seq_fsm
  import maf_xtalk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic ready,
  input  logic last_victim,
  output logic active,
  output logic vic_lvl,
  output logic agg_lvl,
  output logic ctr_clr,
  output logic ctr_adv,
  output logic done
);

  step_t state, state_nxt;
  logic  fire;
  lvl_t  lv;

  assign active = (state != ST_IDLE);
  assign fire   = active && ready;

  always_comb begin
    state_nxt = state;
    unique case (state)
      ST_IDLE: if (start) state_nxt = ST_P1;
      ST_P8:   if (fire)  state_nxt = last_victim ? ST_IDLE : ST_P1;
      default: if (fire)  state_nxt = step_t'(state + 4'd1);
    endcase
  end

  assign ctr_clr = (state == ST_IDLE) && start;
  assign ctr_adv = fire && (state == ST_P8) && !last_victim;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= state_nxt;
      done  <= fire && (state == ST_P8) && last_victim;
    end
  end

  always_comb begin
    lv      = step_levels(state);
    vic_lvl = lv.vic;
    agg_lvl = lv.agg;
  end

endmodule

// File: rtl/maf_victim_ctr.sv
module maf_victim_ctr #(
  parameter int LANES = 8,
  localparam int CW = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          adv,
  output logic [CW-1:0] idx,
  output logic          last
);

  localparam logic [CW-1:0] LAST_IDX = CW'(LANES - 1);

  assign last = (idx == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   idx <= '0;
    else if (clr) idx <= '0;
    else if (adv) idx <= idx + 1'b1;
  end

endmodule

// File: rtl/maf_lane_mux.sv
module maf_lane_mux #(
  parameter int LANES = 8,
  localparam int CW = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic [CW-1:0]    idx,
  input  logic             active,
  input  logic             vic_lvl,
  input  logic             agg_lvl,
  output logic [LANES-1:0] word
);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic sel;
    assign sel     = (idx == CW'(i));
    assign word[i] = active & (sel ? vic_lvl : agg_lvl);
  end

endmodule

// File: rtl/maf_xtalk_gen.sv
module maf_xtalk_gen #(
  parameter int LANES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             ready_i,
  output logic [LANES-1:0] word_o,
  output logic             valid_o,
  output logic             finish_o
);

  localparam int CW = (LANES > 1) ? $clog2(LANES) : 1;

  logic          active, vic_lvl, agg_lvl, ctr_clr, ctr_adv, last_victim;
  logic [CW-1:0] victim_idx;

  maf_seq_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start_i),
    .ready       (ready_i),
    .last_victim (last_victim),
    .active      (active),
    .vic_lvl     (vic_lvl),
    .agg_lvl     (agg_lvl),
    .ctr_clr     (ctr_clr),
    .ctr_adv     (ctr_adv),
    .done        (finish_o)
  );

  maf_victim_ctr #(.LANES(LANES)) u_ctr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (ctr_clr),
    .adv   (ctr_adv),
    .idx   (victim_idx),
    .last  (last_victim)
  );

  maf_lane_mux #(.LANES(LANES)) u_mux (
    .idx     (victim_idx),
    .active  (active),
    .vic_lvl (vic_lvl),
    .agg_lvl (agg_lvl),
    .word    (word_o)
  );

  assign valid_o = active;

endmodule

// File: rtl/maf_xtalk_gen_chk.sv
module maf_xtalk_gen_chk #(
  parameter int LANES = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             ready_i,
  input logic [LANES-1:0] word_o,
  input logic             valid_o,
  input logic             finish_o
);

  p_idle_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> (word_o == '0));

  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid_o && start_i) |=> (valid_o && word_o == '0));

  p_shape_r3: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> ($countones(word_o) <= 1 || $countones(word_o) >= LANES - 1));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ready_i) |=> (valid_o && $stable(word_o)));

  p_finish_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    finish_o |-> !valid_o);

  p_finish_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    finish_o |=> !finish_o);

  p_finish_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(finish_o) |-> $fell(valid_o));

endmodule

bind maf_xtalk_gen maf_xtalk_gen_chk #(.LANES(LANES)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start_i  (start_i),
  .ready_i  (ready_i),
  .word_o   (word_o),
  .valid_o  (valid_o),
  .finish_o (finish_o)
);

// File: tb/tb_maf_xtalk_gen.sv
`timescale 1ns/1ps
module tb_maf_xtalk_gen;

  localparam int LANES = 4;
  localparam int TOTAL = 8 * LANES;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic ready_i = 1'b0;
  logic [LANES-1:0] word_o;
  logic valid_o, finish_o;

  int checks = 0;
  int errors = 0;
  bit done_flag = 0;

  always #2.5 clk = ~clk;

  maf_xtalk_gen #(.LANES(LANES)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .ready_i(ready_i),
    .word_o(word_o), .valid_o(valid_o), .finish_o(finish_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [LANES-1:0] exp_word(input int beat);
    int vic = beat / 8;
    int stp = beat % 8;
    logic v, a;
    logic [LANES-1:0] w;
    case (stp)
      0: begin v = 0; a = 0; end
      1: begin v = 1; a = 1; end
      2: begin v = 0; a = 0; end
      3: begin v = 0; a = 1; end
      4: begin v = 1; a = 0; end
      5: begin v = 0; a = 1; end
      6: begin v = 1; a = 1; end
      default: begin v = 1; a = 0; end
    endcase
    for (int i = 0; i < LANES; i++) w[i] = (i == vic) ? v : a;
    return w;
  endfunction

  // mode 0: ready always high; mode 1: stalls from a pattern;
  // mode 2: stalls plus a start pulse in mid-test.
  task automatic run_test(input int mode, input bit restart_on_finish);
    int beat = 0;
    int cyc = 0;
    start_i = 1'b1;
    ready_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
    chk("R2 valid after start", valid_o, 1);
    chk("R2 first word victim 0 step 1", word_o, '0);
    while (beat < TOTAL) begin
      if (mode == 0) ready_i = 1'b1;
      else ready_i = ((cyc % 5) != 1) && ((cyc % 7) != 3) && ((cyc % 7) != 4);
      if (mode == 2) start_i = (beat == 13);
      chk("R4 valid held during test", valid_o, 1);
      chk("R3 R5 word for beat", word_o, exp_word(beat));
      chk("R7 no finish during test", finish_o, 0);
      if (ready_i) beat++;
      cyc++;
      @(negedge clk);
      start_i = 1'b0;
    end
    chk("R6 valid low after last beat", valid_o, 0);
    chk("R7 finish pulse", finish_o, 1);
    chk("R1 idle word zero", word_o, '0);
    if (restart_on_finish) begin
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      chk("R9 restart in finish cycle", valid_o, 1);
      chk("R9 finish single cycle", finish_o, 0);
      chk("R9 restart word", word_o, exp_word(0));
      ready_i = 1'b1;
      for (int b = 0; b < TOTAL; b++) begin
        chk("R3 R9 restarted beat", word_o, exp_word(b));
        @(negedge clk);
      end
      chk("R9 restarted finish", finish_o, 1);
      @(negedge clk);
    end else begin
      @(negedge clk);
    end
    chk("R7 finish one cycle", finish_o, 0);
    chk("R1 idle valid", valid_o, 0);
  endtask

  initial begin
    #200000;
    if (!done_flag) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset valid", valid_o, 0);
    chk("R1 reset word", word_o, '0);
    chk("R1 reset finish", finish_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: idle with ready high stays idle
    ready_i = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 idle ignores ready", valid_o, 0);
    run_test(0, 1'b0);
    run_test(1, 1'b0);
    run_test(2, 1'b0);   // R8 mid-test start ignored
    run_test(1, 1'b1);
    // R4: long stall holds the first beat
    start_i = 1'b1; ready_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
    repeat (20) @(negedge clk);
    chk("R4 long stall valid", valid_o, 1);
    chk("R4 long stall word", word_o, exp_word(0));
    ready_i = 1'b1;
    for (int b = 0; b < TOTAL; b++) @(negedge clk);
    chk("R6 end after stalled run", valid_o, 0);
    chk("R7 finish after stalled run", finish_o, 1);
    done_flag = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule